// File: doc/BRIEF.md
# Capture/Reload Timer with External Trigger

This block is a 16-bit timer/counter with two main modes.

- **Capture mode:** a falling edge on a trigger pin copies the running count into a holding register.
- **Reload mode:** the counter is preset from that same register. This happens when the count overflows, and also when the trigger pin falls.

The count source is either every clock cycle or falling edges on an external count pin. The count pin is synchronized before it is used.

A reload variant counts up or down, and the trigger pin level picks the direction. In that variant the trigger flag toggles on each wrap instead of recording trigger edges.

Overflow pulses can serve as the receive or transmit baud tick of a serial port. When a side does not select this timer, an alternate overflow pulse is passed through for it. While the block serves as a baud or clock-out source, the overflow flag is held off.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Software writes are single-cycle strobes that are always accepted.

Top module: `cap_reload_timer`

## Requirements
- R1: During and directly after reset, `count` and `reload_cap` are 0x0000, and `ovf_flag`, `ext_flag`, `irq` and the internal overflow pulse are 0.
- R2: With `event_mode`=0 and `run`=1, the count advances once per clock cycle. With `run`=0, the count holds, apart from software writes and trigger reloads.
- R3: With `event_mode`=1, the count advances once per falling edge of `count_pin`. The pin passes through two synchronizer flops, so the step appears at the third rising clock edge after the pin falls.
- R4: Capture mode (`capture_mode`=1, no baud or clock-out select) behaves as follows:
  - A tick at 0xFFFF wraps the count to 0x0000 and sets `ovf_flag`.
  - A synchronized falling edge on `trig_pin` with `trig_en`=1 copies the pre-edge count into `reload_cap` and sets `ext_flag`.
  - The trigger leaves the count untouched.
- R5: Reload mode (`capture_mode`=0, `updown_en`=0) behaves as follows:
  - A tick at 0xFFFF loads `reload_cap` and sets `ovf_flag`.
  - A trigger falling edge with `trig_en`=1 loads `reload_cap` into the count and sets `ext_flag`.
- R6: With `trig_en`=0, trigger edges never set `ext_flag`, capture or reload.
- R7: Up/down mode (`capture_mode`=0, `updown_en`=1, no baud or clock-out select) behaves as follows:
  - A synchronized `trig_pin` level of 1 counts up. In this direction a tick at 0xFFFF loads `reload_cap`.
  - A level of 0 counts down. In this direction a tick with the count equal to `reload_cap` loads 0xFFFF.
  - Each such wrap sets `ovf_flag` and toggles `ext_flag`.
  - Trigger edges and `trig_en` have no effect.
- R8: With `rx_clk_sel`, `tx_clk_sel` or `clkout_en` set, the behaviour is as follows:
  - The count runs up and loads `reload_cap` at 0xFFFF.
  - `ovf_flag` is never set.
  - A trigger edge with `trig_en`=1 only sets `ext_flag`.
- R9: `rx_baud_pulse` is a one-cycle pulse in the cycle after each wrap when `rx_clk_sel`=1; otherwise it equals `alt_ovf_pulse`. `tx_baud_pulse` works the same way with `tx_clk_sel`.
- R10: Each flag clears only on its clear strobe, and a hardware set in the same cycle wins over the clear. `irq` is the OR of the two flags.
- R11: In a single cycle the following priorities apply:
  - A trigger reload beats a `wr_count` write.
  - A capture beats a `wr_reload` write.
  - A `wr_count` write beats a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 lets the counter tick |
| event_mode | input | 1 | 1 counts `count_pin` falls, 0 counts clocks |
| capture_mode | input | 1 | 1 capture mode, 0 reload mode |
| updown_en | input | 1 | 1 enables up/down counting in reload mode |
| trig_en | input | 1 | 1 lets `trig_pin` falls act |
| rx_clk_sel | input | 1 | 1 routes this timer's wraps to `rx_baud_pulse` |
| tx_clk_sel | input | 1 | 1 routes this timer's wraps to `tx_baud_pulse` |
| clkout_en | input | 1 | Clock-out use: forces reload counting, holds off `ovf_flag` |
| count_pin | input | 1 | External event input, asynchronous |
| trig_pin | input | 1 | External trigger / direction input, asynchronous |
| alt_ovf_pulse | input | 1 | Overflow pulse of another timer |
| wr_count | input | 1 | Write strobe for the count |
| wr_reload | input | 1 | Write strobe for the reload/capture register |
| wr_data | input | 16 | Data for both write strobes |
| clr_ovf | input | 1 | Clear strobe for `ovf_flag` |
| clr_ext | input | 1 | Clear strobe for `ext_flag` |
| count | output | 16 | Current count |
| reload_cap | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | Trigger flag (wrap toggle in up/down mode) |
| irq | output | 1 | Interrupt request |
| rx_baud_pulse | output | 1 | Receive baud tick |
| tx_baud_pulse | output | 1 | Transmit baud tick |

## Verification
The bench writes counts and reload values near 0xFFFF. This makes wraps occur often in every mode, including down counting onto an equal reload value. A design that compared against the wrong bound or used the wrong direction there would show a count one step off, or a missing `ext_flag` toggle.

Trigger falls are placed in the same cycle as count and reload writes. This exposes an inverted priority, which would leave the written value in place of the reload or capture.

Baud and clock-out selections are mixed into the random phases. A design that let `ovf_flag` rise in those modes, or that passed the wrong pulse source to a baud output, is caught by the cycle-by-cycle comparison.

// File: rtl/crt_pkg.sv
package crt_pkg;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_UPDOWN  = 2'd2,
    MODE_BAUD    = 2'd3
  } crt_mode_e;

  // Baud / clock-out use overrides the other selections.
  function automatic crt_mode_e crt_decode(input logic cap_sel,
                                           input logic ud_sel,
                                           input logic baud_sel);
    if (baud_sel)     return MODE_BAUD;
    else if (cap_sel) return MODE_CAPTURE;
    else if (ud_sel)  return MODE_UPDOWN;
    else              return MODE_RELOAD;
  endfunction

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("crt_edge_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
  import crt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  crt_mode_e        mode,
  input  logic             tick,
  input  logic             up_dir,
  input  logic             trig_load,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] reload_val,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt  = count;
    wrap = 1'b0;
    if (trig_load) begin
      nxt = reload_val;
    end else if (wr_en) begin
      nxt = wr_data;
    end else if (tick) begin
      if (mode == MODE_UPDOWN && !up_dir) begin
        if (count == reload_val) begin
          nxt  = TOP;
          wrap = 1'b1;
        end else begin
          nxt = count - ONE;
        end
      end else if (count == TOP) begin
        wrap = 1'b1;
        nxt  = (mode == MODE_CAPTURE) ? '0 : reload_val;
      end else begin
        nxt = count + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end
endmodule

// File: rtl/crt_flags.sv
module crt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_hit,
  input  logic wrap,
  input  logic ud_mode,
  input  logic baud_like,
  input  logic clr_ovf,
  input  logic clr_ext,
  output logic ovf_flag,
  output logic ext_flag,
  output logic ovf_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      ext_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      if (wrap && !baud_like) ovf_flag <= 1'b1;
      else if (clr_ovf)       ovf_flag <= 1'b0;
      if (trig_hit)            ext_flag <= 1'b1;
      else if (wrap && ud_mode) ext_flag <= ~ext_flag;
      else if (clr_ext)        ext_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             event_mode,
  input  logic             capture_mode,
  input  logic             updown_en,
  input  logic             trig_en,
  input  logic             rx_clk_sel,
  input  logic             tx_clk_sel,
  input  logic             clkout_en,
  input  logic             count_pin,
  input  logic             trig_pin,
  input  logic             alt_ovf_pulse,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             clr_ovf,
  input  logic             clr_ext,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] reload_cap,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             irq,
  output logic             rx_baud_pulse,
  output logic             tx_baud_pulse
);
  logic      cnt_level, cnt_fall;
  logic      trig_level, trig_fall;
  logic      baud_like, ud_mode, trig_hit;
  logic      cap_ev, reload_ev, tick, wrap, ovf_pulse;
  crt_mode_e mode;

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin),
    .level(cnt_level), .fall(cnt_fall)
  );

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin),
    .level(trig_level), .fall(trig_fall)
  );

  assign baud_like = rx_clk_sel | tx_clk_sel | clkout_en;
  assign mode      = crt_decode(capture_mode, updown_en, baud_like);
  assign ud_mode   = (mode == MODE_UPDOWN);
  assign trig_hit  = trig_fall & trig_en & ~ud_mode;
  assign cap_ev    = trig_hit & (mode == MODE_CAPTURE);
  assign reload_ev = trig_hit & (mode == MODE_RELOAD);
  assign tick      = run & (event_mode ? cnt_fall : 1'b1);

  crt_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
    .up_dir(trig_level), .trig_load(reload_ev), .wr_en(wr_count),
    .wr_data(wr_data), .reload_val(reload_cap),
    .count(count), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_cap <= '0;
    else if (cap_ev)    reload_cap <= count;
    else if (wr_reload) reload_cap <= wr_data;
  end

  crt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .trig_hit(trig_hit), .wrap(wrap),
    .ud_mode(ud_mode), .baud_like(baud_like),
    .clr_ovf(clr_ovf), .clr_ext(clr_ext),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .ovf_pulse(ovf_pulse)
  );

  assign irq           = ovf_flag | ext_flag;
  assign rx_baud_pulse = rx_clk_sel ? ovf_pulse : alt_ovf_pulse;
  assign tx_baud_pulse = tx_clk_sel ? ovf_pulse : alt_ovf_pulse;
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             trig_en,
  input logic             wr_count,
  input logic             clr_ovf,
  input logic             baud_like,
  input logic             ud_mode,
  input logic             cap_ev,
  input logic             reload_ev,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] reload_cap,
  input logic             ovf_flag,
  input logic             ext_flag
);
  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(clr_ovf));

  // R8
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> !$past(baud_like));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count && !reload_ev) |=> $stable(count));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (reload_cap == $past(count)));

  // R6
  trig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en && !ud_mode) |=> !$rose(ext_flag));

  // R11
  trig_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_ev && wr_count) |=> (count == $past(reload_cap)));
endmodule

bind cap_reload_timer crt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .trig_en(trig_en),
  .wr_count(wr_count), .clr_ovf(clr_ovf), .baud_like(baud_like),
  .ud_mode(ud_mode), .cap_ev(cap_ev), .reload_ev(reload_ev),
  .count(count), .reload_cap(reload_cap),
  .ovf_flag(ovf_flag), .ext_flag(ext_flag)
);

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, event_mode = 0, capture_mode = 0, updown_en = 0, trig_en = 0;
  logic rx_clk_sel = 0, tx_clk_sel = 0, clkout_en = 0;
  logic count_pin = 0, trig_pin = 0, alt_ovf_pulse = 0;
  logic wr_count = 0, wr_reload = 0, clr_ovf = 0, clr_ext = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] count, reload_cap;
  logic ovf_flag, ext_flag, irq, rx_baud_pulse, tx_baud_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .event_mode(event_mode),
    .capture_mode(capture_mode), .updown_en(updown_en), .trig_en(trig_en),
    .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel), .clkout_en(clkout_en),
    .count_pin(count_pin), .trig_pin(trig_pin), .alt_ovf_pulse(alt_ovf_pulse),
    .wr_count(wr_count), .wr_reload(wr_reload), .wr_data(wr_data),
    .clr_ovf(clr_ovf), .clr_ext(clr_ext),
    .count(count), .reload_cap(reload_cap), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .irq(irq),
    .rx_baud_pulse(rx_baud_pulse), .tx_baud_pulse(tx_baud_pulse)
  );

  // Reference model built from the requirements.
  logic [15:0] m_cnt, m_rel;
  logic m_ovf, m_ext, m_pulse;
  logic c_s1, c_s2, c_prev, t_s1, t_s2, t_prev;
  logic e_cfall, e_tfall, e_bl, e_ud, e_hit, e_tick, e_wrap;
  logic [15:0] e_nc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_rel <= '0; m_ovf <= 0; m_ext <= 0; m_pulse <= 0;
      c_s1 <= 0; c_s2 <= 0; c_prev <= 0; t_s1 <= 0; t_s2 <= 0; t_prev <= 0;
    end else begin
      e_cfall = c_prev & ~c_s2;                       // R3 third edge
      e_tfall = t_prev & ~t_s2;
      e_bl    = rx_clk_sel | tx_clk_sel | clkout_en;
      e_ud    = !capture_mode && updown_en && !e_bl;
      e_hit   = e_tfall && trig_en && !e_ud;
      e_tick  = run && (event_mode ? e_cfall : 1'b1);
      e_nc    = m_cnt;
      e_wrap  = 0;
      if (e_hit && !capture_mode && !e_bl) e_nc = m_rel;   // R11
      else if (wr_count) e_nc = wr_data;
      else if (e_tick) begin
        if (e_ud && !t_s2) begin                          // R7 down
          if (m_cnt == m_rel) begin e_nc = 16'hFFFF; e_wrap = 1; end
          else e_nc = m_cnt - 16'd1;
        end else if (m_cnt == 16'hFFFF) begin
          e_wrap = 1;
          e_nc = (capture_mode && !e_bl) ? 16'h0000 : m_rel;
        end else e_nc = m_cnt + 16'd1;
      end
      m_cnt <= e_nc;
      if (e_hit && capture_mode && !e_bl) m_rel <= m_cnt;
      else if (wr_reload) m_rel <= wr_data;
      if (e_hit) m_ext <= 1'b1;
      else if (e_wrap && e_ud) m_ext <= ~m_ext;
      else if (clr_ext) m_ext <= 1'b0;
      if (e_wrap && !e_bl) m_ovf <= 1'b1;
      else if (clr_ovf) m_ovf <= 1'b0;
      m_pulse <= e_wrap;
      c_s1 <= count_pin; c_s2 <= c_s1; c_prev <= c_s2;
      t_s1 <= trig_pin;  t_s2 <= t_s1; t_prev <= t_s2;
    end
  end

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string count_tag();
    if (rx_clk_sel || tx_clk_sel || clkout_en) return "R8 count";
    if (event_mode) return "R3 count";
    if (capture_mode) return "R4 count";
    if (updown_en) return "R7 count";
    return "R5 count";
  endfunction

  task automatic compare_all();
    chk(count_tag(), {16'h0, count}, {16'h0, m_cnt});
    chk("R4 reload_cap", {16'h0, reload_cap}, {16'h0, m_rel});
    chk((rx_clk_sel || tx_clk_sel || clkout_en) ? "R8 ovf_flag" : "R10 ovf_flag",
        {31'h0, ovf_flag}, {31'h0, m_ovf});
    chk(trig_en ? "R10 ext_flag" : "R6 ext_flag", {31'h0, ext_flag}, {31'h0, m_ext});
    chk("R10 irq", {31'h0, irq}, {31'h0, m_ovf | m_ext});
    chk("R9 rx_baud", {31'h0, rx_baud_pulse},
        {31'h0, rx_clk_sel ? m_pulse : alt_ovf_pulse});
    chk("R9 tx_baud", {31'h0, tx_baud_pulse},
        {31'h0, tx_clk_sel ? m_pulse : alt_ovf_pulse});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", {16'h0, count}, 32'h0);
    chk("R1 reload_cap", {16'h0, reload_cap}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    step();
    chk("R1 flags", {30'h0, ovf_flag, ext_flag}, 32'h0);

    // R11 trigger reload beats count write
    trig_en = 1; trig_pin = 1;
    wr_reload = 1; wr_data = 16'h1234;
    step();
    wr_reload = 0;
    repeat (4) step();
    trig_pin = 0; wr_count = 1; wr_data = 16'h5555;
    step(); step(); step();
    chk("R11 reload over write", {16'h0, count}, 32'h1234);
    chk("R5 ext_flag set", {31'h0, ext_flag}, 32'h1);
    wr_count = 0; clr_ext = 1;
    step();
    clr_ext = 0;

    // R11 capture beats reload write
    capture_mode = 1; wr_count = 1; wr_data = 16'h00AA; trig_pin = 1;
    step();
    wr_count = 0;
    repeat (4) step();
    trig_pin = 0; wr_reload = 1; wr_data = 16'h7777;
    step(); step(); step();
    chk("R11 capture over write", {16'h0, reload_cap}, 32'h00AA);
    wr_reload = 0;

    // R4 capture wrap to zero
    wr_count = 1; wr_data = 16'hFFFE;
    step();
    wr_count = 0; run = 1;
    step(); step();
    chk("R4 wrap to zero", {16'h0, count}, 32'h0);
    chk("R4 ovf set", {31'h0, ovf_flag}, 32'h1);
    run = 0; clr_ovf = 1; clr_ext = 1;
    step();
    clr_ovf = 0; clr_ext = 0;

    // Random phases mixed across all modes
    for (int ph = 0; ph < 60; ph++) begin
      capture_mode = $urandom_range(0, 2) == 0;
      updown_en    = $urandom_range(0, 1);
      event_mode   = $urandom_range(0, 3) == 0;
      trig_en      = $urandom_range(0, 3) != 0;
      rx_clk_sel   = $urandom_range(0, 5) == 0;
      tx_clk_sel   = $urandom_range(0, 5) == 0;
      clkout_en    = $urandom_range(0, 7) == 0;
      for (int cy = 0; cy < 150; cy++) begin
        run = $urandom_range(0, 19) != 0;
        if ($urandom_range(0, 2) == 0) count_pin = ~count_pin;
        if ($urandom_range(0, 11) == 0) trig_pin = ~trig_pin;
        alt_ovf_pulse = $urandom_range(0, 3) == 0;
        wr_count  = $urandom_range(0, 39) == 0;
        wr_reload = $urandom_range(0, 49) == 0;
        wr_data   = $urandom_range(0, 1) ? (16'hFFF0 | 16'($urandom_range(0, 15)))
                                         : 16'($urandom_range(0, 65535));
        clr_ovf = $urandom_range(0, 19) == 0;
        clr_ext = $urandom_range(0, 19) == 0;
        step();
      end
    end
    finish_run();
  end
endmodule